// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block sits between the instruction memory bus and the execute unit. It keeps a small queue of instruction words ready to use. Whenever the bus has a free slot, it fetches the next sequential word ahead of need, so opcodes and operands are often already waiting when the execute unit asks for them. The queue holds three words by default. It only ever issues reads: data writes go to memory on their own path, and the arbiter takes the bus from the queue by holding back the grant.

The execute unit takes words from the head through a valid/ready port. Words leave in the order they were fetched, and each carries the byte address it came from. Execution is not overlapped. The execute unit pulls the next instruction only after the current one has finished, even when that instruction is already queued.

A taken branch raises the flush input with the target address. All queued words are discarded, and fetching restarts at the word-aligned target. An untaken branch needs no action, because the following word is already at the head of the queue.

Top module: `ifq_top`

## Requirements
- R1: After reset the queue is empty: `level` is 0 and `out_valid` is 0. `fetch_addr` equals the RESET_ADDR parameter.
- R2: `fetch_req` is high exactly when `level` is below DEPTH and `flush` is low.
- R3: A fetch completes in any cycle where `fetch_req` and `bus_gnt` are both high. `bus_rdata` is taken in that cycle, and `fetch_addr` advances by 2. In a cycle with no completed fetch and no flush, `fetch_addr` and the queue contents stay unchanged.
- R4: Words leave the head in fetch order. `out_addr` is the byte address the head word was fetched from, and `out_data` is the word read at that address.
- R5: `out_valid` is high exactly when `level` is nonzero. A word is consumed when `out_valid` and `out_ready` are both high. While the queue is empty, `out_ready` has no effect, and the consumer waits until a fetch completes.
- R6: If a fetch completes and a word is consumed in the same cycle, `level` stays the same and the head moves on to the next word.
- R7: When `flush` is high at a clock edge, the next cycle shows `level` 0 and `out_valid` 0. `fetch_addr` becomes `flush_target` with bit 0 cleared. A consume requested in the flush cycle is ignored.
- R8: If `bus_gnt` is held high from the flush cycle onward, the target word is valid at the head after the second clock edge that follows the flush cycle's start.
- R9: `level` never exceeds DEPTH. While the queue is full, no fetch is issued and `fetch_addr` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | output | 1 | Queue wants a bus slot for an instruction read |
| fetch_addr | output | 16 | Byte address of the next instruction word |
| bus_gnt | input | 1 | Bus slot free for an instruction read this cycle (low while a data access owns the bus) |
| bus_rdata | input | 16 | Word read at `fetch_addr`, valid in the granted cycle |
| flush | input | 1 | Taken branch: discard the queue and restart fetching |
| flush_target | input | 16 | Branch target byte address |
| out_valid | output | 1 | Head word available |
| out_ready | input | 1 | Execute unit consumes the head word |
| out_data | output | 16 | Head instruction word |
| out_addr | output | 16 | Byte address of the head word |
| level | output | 2 | Number of valid queued words |

## Verification
The bench builds the block with the default depth of three and RESET_ADDR set to 0x0100. The nonzero reset address makes the reset value and every later fetch address distinct from zero. With a depth of three, the bench reaches the full state in three granted cycles, so it can check that fetching stops when the queue is full and that a flush discards a full queue. The flush target is odd, which exercises word alignment. Withheld grants stand in for data writes that take the bus.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
  parameter int unsigned IFQ_DATA_W = 16;
  parameter int unsigned IFQ_ADDR_W = 16;

  typedef struct packed {
    logic [IFQ_ADDR_W-1:0] addr;
    logic [IFQ_DATA_W-1:0] data;
  } ifq_word_t;
endpackage

// File: rtl/ifq_fetch.sv
module ifq_fetch #(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned LVL_W = 2,
  parameter logic [ifq_pkg::IFQ_ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic [ifq_pkg::IFQ_ADDR_W-1:0] flush_target,
  input  logic [LVL_W-1:0]              level,
  input  logic                          bus_gnt,
  output logic                          fetch_req,
  output logic [ifq_pkg::IFQ_ADDR_W-1:0] fetch_addr,
  output logic                          fill
);
  localparam int unsigned AW = ifq_pkg::IFQ_ADDR_W;
  localparam logic [AW-1:0] STEP = AW'(ifq_pkg::IFQ_DATA_W / 8);

  logic [AW-1:0] pc_q;

  assign fetch_req  = !flush && (level < LVL_W'(DEPTH));
  assign fill       = fetch_req && bus_gnt;
  assign fetch_addr = pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     pc_q <= RESET_ADDR;
    else if (flush) pc_q <= flush_target & ~AW'(1);
    else if (fill)  pc_q <= pc_q + STEP;
  end
endmodule

// File: rtl/ifq_store.sv
module ifq_store #(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned LVL_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               push,
  input  ifq_pkg::ifq_word_t push_word,
  input  logic               pop,
  output ifq_pkg::ifq_word_t head_word,
  output logic [LVL_W-1:0]   level
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] cnt_q;
  ifq_pkg::ifq_word_t slots [DEPTH];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    ifq_pkg::ifq_word_t slot_q;
    always_ff @(posedge clk) begin
      if (push && !clr && wr_ptr == PTR_W'(i)) slot_q <= push_word;
    end
    assign slots[i] = slot_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + LVL_W'(1);
        2'b01:   cnt_q <= cnt_q - LVL_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_word = slots[rd_ptr];
  assign level     = cnt_q;
endmodule

// File: rtl/ifq_top.sv
module ifq_top #(
  parameter int unsigned DEPTH = 3,
  parameter logic [ifq_pkg::IFQ_ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  output logic                            fetch_req,
  output logic [ifq_pkg::IFQ_ADDR_W-1:0]  fetch_addr,
  input  logic                            bus_gnt,
  input  logic [ifq_pkg::IFQ_DATA_W-1:0]  bus_rdata,
  input  logic                            flush,
  input  logic [ifq_pkg::IFQ_ADDR_W-1:0]  flush_target,
  output logic                            out_valid,
  input  logic                            out_ready,
  output logic [ifq_pkg::IFQ_DATA_W-1:0]  out_data,
  output logic [ifq_pkg::IFQ_ADDR_W-1:0]  out_addr,
  output logic [$clog2(DEPTH+1)-1:0]      level
);
  localparam int unsigned LVL_W = $clog2(DEPTH + 1);

  logic               fill, take;
  ifq_pkg::ifq_word_t in_word, head_word;

  assign in_word.addr = fetch_addr;
  assign in_word.data = bus_rdata;
  assign out_valid    = (level != '0);
  assign take         = out_valid && out_ready && !flush;
  assign out_data     = head_word.data;
  assign out_addr     = head_word.addr;

  ifq_fetch #(.DEPTH(DEPTH), .LVL_W(LVL_W), .RESET_ADDR(RESET_ADDR)) u_fetch (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_target(flush_target),
    .level(level), .bus_gnt(bus_gnt), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .fill(fill)
  );

  ifq_store #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(flush), .push(fill), .push_word(in_word),
    .pop(take), .head_word(head_word), .level(level)
  );
endmodule

// File: rtl/ifq_chk.sv
module ifq_chk #(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned LVL_W = 2,
  parameter int unsigned AW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_req,
  input logic [AW-1:0]    fetch_addr,
  input logic             bus_gnt,
  input logic             flush,
  input logic [AW-1:0]    flush_target,
  input logic             out_valid,
  input logic             out_ready,
  input logic [LVL_W-1:0] level
);
  // R9
  level_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));
  // R2
  full_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LVL_W'(DEPTH)) |-> !fetch_req);
  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && bus_gnt) |=> (fetch_addr == $past(fetch_addr) + AW'(2)));
  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(fetch_req && bus_gnt) && !flush) |=> $stable(fetch_addr));
  // R7
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0 && fetch_addr == ($past(flush_target) & ~AW'(1))));
  // R5
  valid_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (level != '0));
  // R6
  fill_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && fetch_req && bus_gnt && out_valid && out_ready) |=> $stable(level));
endmodule

bind ifq_top ifq_chk #(.DEPTH(DEPTH), .LVL_W($clog2(DEPTH+1)), .AW(ifq_pkg::IFQ_ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
  .bus_gnt(bus_gnt), .flush(flush), .flush_target(flush_target),
  .out_valid(out_valid), .out_ready(out_ready), .level(level)
);

// File: tb/tb_ifq_top.sv
module tb_ifq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req;
  logic [15:0] fetch_addr;
  logic        bus_gnt = 1'b0;
  logic [15:0] bus_rdata;
  logic        flush = 1'b0;
  logic [15:0] flush_target = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic [15:0] out_addr;
  logic [1:0]  level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // memory model: each word is its address mixed with a constant
  function automatic logic [15:0] mem_word(input logic [15:0] a);
    return a ^ 16'hA5C3;
  endfunction
  assign bus_rdata = mem_word(fetch_addr);

  ifq_top #(.DEPTH(3), .RESET_ADDR(16'h0100)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .flush(flush),
    .flush_target(flush_target), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_addr(out_addr), .level(level)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    repeat (3) step();
    rst_n = 1'b1;
    chk("R1 level", 32'(level), 0);
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 fetch_addr", 32'(fetch_addr), 32'h0100);
    chk("R2 req when empty", 32'(fetch_req), 1);
  endtask

  task automatic t_no_grant();
    bus_gnt = 1'b0;
    repeat (3) step();
    chk("R3 addr held without grant", 32'(fetch_addr), 32'h0100);
    chk("R3 level held without grant", 32'(level), 0);
  endtask

  task automatic t_fill_order();
    bus_gnt = 1'b1;
    step();
    chk("R3 level after one fetch", 32'(level), 1);
    chk("R3 addr advanced", 32'(fetch_addr), 32'h0102);
    step(); step();
    chk("R9 level full", 32'(level), 3);
    chk("R2 no req when full", 32'(fetch_req), 0);
    step();
    chk("R9 level saturates", 32'(level), 3);
    chk("R9 addr held when full", 32'(fetch_addr), 32'h0106);
    bus_gnt = 1'b0;
    out_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      chk("R4 head addr", 32'(out_addr), 32'h0100 + 32'(2 * i));
      chk("R4 head data", 32'(out_data), 32'(mem_word(16'h0100 + 16'(2 * i))));
      step();
    end
    chk("R5 empty after drain", 32'(out_valid), 0);
    step();
    chk("R5 ready on empty ignored", 32'(level), 0);
    chk("R5 addr unchanged", 32'(fetch_addr), 32'h0106);
    out_ready = 1'b0;
  endtask

  task automatic t_simul();
    bus_gnt = 1'b1;
    step();
    chk("R5 valid after fetch", 32'(out_valid), 1);
    chk("R4 head", 32'(out_addr), 32'h0106);
    out_ready = 1'b1;
    step();
    chk("R6 level kept", 32'(level), 1);
    chk("R6 head moved", 32'(out_addr), 32'h0108);
    out_ready = 1'b0;
    step(); step();
    chk("R9 refilled", 32'(level), 3);
  endtask

  task automatic t_flush();
    flush = 1'b1;
    flush_target = 16'h2345;
    out_ready = 1'b1;
    bus_gnt = 1'b1;
    step();
    flush = 1'b0;
    out_ready = 1'b0;
    chk("R7 level cleared", 32'(level), 0);
    chk("R7 out_valid low", 32'(out_valid), 0);
    chk("R7 aligned target", 32'(fetch_addr), 32'h2344);
    step();
    chk("R8 target valid", 32'(out_valid), 1);
    chk("R8 target addr", 32'(out_addr), 32'h2344);
    chk("R8 target data", 32'(out_data), 32'(mem_word(16'h2344)));
    bus_gnt = 1'b0;
  endtask

  initial begin
    t_reset();
    t_no_grant();
    t_fill_order();
    t_simul();
    t_flush();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule